// File: doc/BRIEF.md
# Programmable System Clock Divider

This block slows down everything that runs off the master clock. It does this with a single clock-enable strobe, not a derived clock. An 8-bit control register drives it. The top bit turns the divider on. The lower seven bits hold a field `d`. While the divider is on, the strobe goes high for one master cycle out of every `129 - d`. So the period runs from 2 cycles (d = 127) to 129 cycles (d = 0). While the divider is off, the strobe stays high on every cycle and logic downstream runs at full rate.

The field is locked while the divider runs. It is taken only from the write that turns the divider on. A write that turns the divider off keeps the stored field and drops the field value it carries. A write that leaves the divider on changes nothing. Software can turn the divider on and off at any time. Each time it turns on, the period counter starts again from zero. The register always reads back what it holds.

Top module: `sysClkScaler`

## Requirements
- R1: After reset the register reads 0x00 and the strobe is high.
- R2: While the enable bit (bit 7) reads 0, the strobe is high on every cycle.
- R3: A write with bit 7 = 1 while the divider is off stores bits 6..0 as `d` and sets the enable bit. From the next cycle the register reads back exactly the written byte.
- R4: While the divider is on, consecutive strobe pulses are exactly `129 - d` cycles apart. For example, d = 0 gives 129, d = 64 gives 65 and d = 127 gives 2.
- R5: A write with bit 7 = 1 while the divider is already on is ignored. The readback does not change and neither does the strobe spacing.
- R6: A write with bit 7 = 0 clears the enable bit and leaves the stored `d` as it was. The readback becomes {0, old d}, whatever bits 6..0 the write carried.
- R7: When a write turns the divider on, the period counter restarts. The strobe is low in the cycle after that write, and the first pulse comes `129 - d` cycles after the write edge.
- R8: In the cycle after a write that clears the enable bit, the strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWrData | input | 8 | Write data: bit 7 is enable, bits 6..0 are `d` |
| regRdData | output | 8 | Stored register value: {enable, d} |
| tickEn | output | 1 | Clock-enable strobe for the CPU and peripherals |

## Verification
A register write can arrive in the same cycle in which the period counter wraps and the strobe fires. The write and the counter advance then act on the same edge. The case is provoked at d = 127, where every other cycle carries a strobe. Back-to-back ignored writes are issued there, and the strobe spacing is then measured and checked to still be 2. The same alignment is used with a disabling write, which must give a high strobe on the very next cycle however the counter stood.

// File: rtl/sysClkScalerPkg.sv
package sysClkScalerPkg;
  // Commands issued by the control path to the datapath.
  typedef struct packed {
    logic arm;     // divider turns on: load field, restart counter
    logic disarm;  // divider turns off: field kept
  } scalerCmd_t;
endpackage

// File: rtl/sysClkScalerCtrl.sv
module sysClkScalerCtrl
  import sysClkScalerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       wrEnableBit,
  output logic       enabled,
  output scalerCmd_t cmd
);
  always_comb begin
    cmd.arm    = regWrEn && wrEnableBit && !enabled;
    cmd.disarm = regWrEn && !wrEnableBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           enabled <= 1'b0;
    else if (cmd.arm)    enabled <= 1'b1;
    else if (cmd.disarm) enabled <= 1'b0;
  end
endmodule

// File: rtl/sysClkScalerPath.sv
module sysClkScalerPath
  import sysClkScalerPkg::*;
#(
  parameter int FIELD_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  scalerCmd_t         cmd,
  input  logic               enabled,
  input  logic [FIELD_W-1:0] wrField,
  output logic [FIELD_W-1:0] field,
  output logic               tickEn
);
  localparam int CNT_W = FIELD_W + 1;
  localparam int BASE  = (1 << FIELD_W) + 1;  // divisor = BASE - field

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastIdx;

  assign lastIdx = CNT_W'(BASE - 1) - {1'b0, field};
  assign tickEn  = !enabled || (count == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        field <= '0;
    else if (cmd.arm) field <= wrField;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 count <= '0;
    else if (cmd.arm)          count <= '0;
    else if (!enabled)         count <= '0;
    else if (count == lastIdx) count <= '0;
    else                       count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/sysClkScaler.sv
module sysClkScaler
  import sysClkScalerPkg::*;
#(
  parameter int FIELD_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [FIELD_W:0] regWrData,
  output logic [FIELD_W:0] regRdData,
  output logic             tickEn
);
  scalerCmd_t         cmd;
  logic               enabled;
  logic [FIELD_W-1:0] field;

  sysClkScalerCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .wrEnableBit (regWrData[FIELD_W]),
    .enabled     (enabled),
    .cmd         (cmd)
  );

  sysClkScalerPath #(.FIELD_W(FIELD_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .enabled (enabled),
    .wrField (regWrData[FIELD_W-1:0]),
    .field   (field),
    .tickEn  (tickEn)
  );

  assign regRdData = {enabled, field};
endmodule

// File: rtl/sysClkScalerChecker.sv
module sysClkScalerChecker #(
  parameter int FIELD_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [FIELD_W:0] regWrData,
  input logic [FIELD_W:0] regRdData,
  input logic             tickEn
);
  // R2: divider off means a strobe on every cycle
  a_r2_off_full_rate: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[FIELD_W] |-> tickEn);

  // R3: enabling write is reflected in readback
  a_r3_load_on_enable: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[FIELD_W] && regWrEn && regWrData[FIELD_W])
      |=> (regRdData == $past(regWrData)));

  // R4: period is at least 2, so no two adjacent strobes while running
  a_r4_no_adjacent_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[FIELD_W] && tickEn && !(regWrEn && !regWrData[FIELD_W]))
      |=> !tickEn);

  // R5: write keeping the divider on changes nothing
  a_r5_locked_field: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[FIELD_W] && regWrEn && regWrData[FIELD_W]) |=> $stable(regRdData));

  // R6: disabling write keeps the field
  a_r6_clear_keeps_field: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrData[FIELD_W])
      |=> (!regRdData[FIELD_W] && regRdData[FIELD_W-1:0] == $past(regRdData[FIELD_W-1:0])));

  // R7: counter restart means no strobe right after turning on
  a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[FIELD_W] && regWrEn && regWrData[FIELD_W]) |=> !tickEn);

  // R8: full rate immediately after disabling
  a_r8_off_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrData[FIELD_W]) |=> tickEn);
endmodule

bind sysClkScaler sysClkScalerChecker #(.FIELD_W(FIELD_W)) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .tickEn    (tickEn)
);

// File: tb/tb_sysClkScaler.sv
module tb_sysClkScaler;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       tickEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  sysClkScaler dut (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .tickEn    (tickEn)
  );

  // {d, expected spacing = 129 - d}
  localparam logic [15:0] VEC [0:4] = '{
    {8'd0,   8'd129},
    {8'd64,  8'd65},
    {8'd127, 8'd2},
    {8'd1,   8'd128},
    {8'd100, 8'd29}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] data);
    @(posedge clk); #1;
    regWrEn = 1'b1; regWrData = data;
    @(posedge clk); #1;
    regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  // Number of samples up to and including the next strobe.
  task automatic cyclesToTick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tickEn && n < 300);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] d;
    int p;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1, R2: reset state and full rate
    @(negedge clk);
    check(regRdData == 8'h00, "R1 readback", regRdData, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(tickEn == 1'b1, "R2 full rate", tickEn, 1);
    end

    // Table walk
    for (int v = 0; v < 5; v++) begin
      d = VEC[v][15:8];
      p = int'(VEC[v][7:0]);
      wrReg({1'b1, d[6:0]});
      check(regRdData == {1'b1, d[6:0]}, "R3 readback", regRdData, {1'b1, d[6:0]});
      check(tickEn == 1'b0, "R7 quiet after enable", tickEn, 0);
      cyclesToTick(n);
      check(n == p, "R7 first strobe", n, p);
      cyclesToTick(n);
      check(n == p, "R4 spacing", n, p);
      // R6: disabling write with different field bits
      wrReg({1'b0, ~d[6:0]});
      check(regRdData == {1'b0, d[6:0]}, "R6 field kept", regRdData, {1'b0, d[6:0]});
      @(negedge clk);
      check(tickEn == 1'b1, "R8 full rate after disable", tickEn, 1);
    end

    // R5: ignored write while running (d = 64)
    wrReg(8'hC0);
    cyclesToTick(n);
    wrReg(8'h85);
    check(regRdData == 8'hC0, "R5 readback locked", regRdData, 8'hC0);
    cyclesToTick(n);
    cyclesToTick(n);
    check(n == 65, "R5 spacing unchanged", n, 65);

    // R6 then re-enable: field loaded only from enabling write
    wrReg(8'h05);
    check(regRdData == 8'h40, "R6 discard on clear", regRdData, 8'h40);
    wrReg(8'hFF);
    check(regRdData == 8'hFF, "R3 new field", regRdData, 8'hFF);

    // Writes coinciding with strobes at d = 127 (period 2)
    for (int k = 0; k < 4; k++) wrReg(8'h81);
    check(regRdData == 8'hFF, "R5 locked under strobes", regRdData, 8'hFF);
    cyclesToTick(n);
    cyclesToTick(n);
    check(n == 2, "R4 spacing after writes", n, 2);
    cyclesToTick(n);
    wrReg(8'h00);
    @(negedge clk);
    check(tickEn == 1'b1, "R8 disable on strobe cycle", tickEn, 1);
    check(regRdData == 8'h7F, "R6 field after disable", regRdData, 8'h7F);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(tickEn == 1'b1, "R2 full rate again", tickEn, 1);
    end

    // R1: reset returns to zero
    #1 rstN = 1'b0;
    @(negedge clk);
    check(regRdData == 8'h00 && tickEn, "R1 reset again", regRdData, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule